// File: doc/BRIEF.md
# Parallel Multi-Lane Serial DAC Writer

This block loads a bank of serial DACs in one shared transfer. It receives a one-cycle start strobe and a flat vector with one word per channel. It stores every word when the strobe arrives. It then shifts all the words out together, most significant bit first, with one data lane per channel. All lanes share one serial clock and one chip-select. The serial clock runs at half the system clock, so each bit lasts two system cycles and a 16-bit word takes 32 cycles.

Chip-select stays low while the block is idle. It is driven high for one cycle only, the first cycle of a transfer, to frame the new word. `busy_o` covers the shifting window. `done_o` pulses once after the final bit. The block does not decide when to load or which values to load.

Top module: `par_dac_writer`

## Requirements
- R1: After reset and whenever idle, `cs_o`, `sclk_o`, `busy_o`, `done_o` and every bit of `sdata_o` are 0.
- R2: A start strobe sampled while idle makes the next cycle the first busy cycle. `cs_o` is 1 in that cycle and in no other cycle of the transfer.
- R3: A transfer holds `busy_o` high for exactly 2*WORD_W cycles. Within each 2-cycle bit period, `sclk_o` is 0 in the first cycle and 1 in the second, which gives WORD_W rising edges per transfer.
- R4: Each lane presents its word MSB first. A data bit changes only when `sclk_o` falls, so `sdata_o` is equal in both cycles of a bit period.
- R5: All lanes shift at the same time in one transfer. Lane k (bit k of `sdata_o`) carries the word in `words_i[k*WORD_W +: WORD_W]`, and this holds for lane 0 and for the last lane.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last busy cycle, and `busy_o` is 0 in that cycle.
- R7: A start strobe that arrives while `busy_o` is 1 is ignored. It causes no extra transfer and does not alter the transfer in progress.
- R8: Words are captured on the accepted start strobe. Changes to `words_i` during a transfer do not affect the shifted data.
- R9: A start strobe sampled in the `done_o` cycle is accepted and starts the next transfer immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to load all channels |
| words_i | input | NUM_CH*WORD_W | Channel words, channel k in bits [k*WORD_W +: WORD_W] |
| sclk_o | output | 1 | Shared serial clock, half the system rate |
| cs_o | output | 1 | Shared chip-select, high for one framing cycle |
| sdata_o | output | NUM_CH | One serial data lane per channel |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
The hardest situations to reach from the ports are the races at the edges of a transfer: a start strobe in the last cycles of shifting, a start strobe in the single `done_o` cycle, and input words that change while bits are still leaving. The stimulus waits for `done_o` at the sampling point and raises the next strobe in that same cycle. It injects a stray strobe with different words partway through a transfer. After every accepted strobe it overwrites `words_i` with the complement of the words. A monitor rebuilds each lane from the bits present at `sclk_o` high and compares the result with the words queued by the driver. It also checks framing and stability cycle by cycle.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int unsigned CYC_PER_BIT = 2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pdw_seq.sv
module pdw_seq
  import pdw_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic sclk_o,
  output logic cs_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned N_CYC = WORD_W * CYC_PER_BIT;
  localparam int unsigned CNT_W = $clog2(N_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SHIFT;
          cnt_q   <= '0;
        end
        ST_SHIFT: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == ST_SHIFT);
  assign load_o  = start_i && (state_q == ST_IDLE);
  // Bit period: low half then high half; the next bit appears as sclk falls
  assign sclk_o  = busy_o && cnt_q[0];
  assign shift_o = busy_o && cnt_q[0];
  assign cs_o    = busy_o && (cnt_q == '0);
  assign done_o  = done_q;

  p_cs_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |=> !cs_o);
  p_cs_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> busy_o);
  p_run_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> (busy_o && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_accept_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> cs_o);
endmodule

// File: rtl/pdw_lane.sv
module pdw_lane #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[WORD_W-1];

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/par_dac_writer.sv
module par_dac_writer #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NUM_CH*WORD_W-1:0] words_i,
  output logic                     sclk_o,
  output logic                     cs_o,
  output logic [NUM_CH-1:0]        sdata_o,
  output logic                     busy_o,
  output logic                     done_o
);
  logic              load;
  logic              shift;
  logic [NUM_CH-1:0] lane_bit;

  pdw_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .sclk_o  (sclk_o),
    .cs_o    (cs_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    pdw_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .word_i  (words_i[k*WORD_W +: WORD_W]),
      .bit_o   (lane_bit[k])
    );
  end

  assign sdata_o = busy_o ? lane_bit : '0;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !cs_o && sdata_o == '0));
  p_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));
  p_start_on_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> cs_o);
endmodule

// File: tb/tb_par_dac_writer.sv
module tb_par_dac_writer;
  localparam int NUM_CH = 32;
  localparam int WORD_W = 16;
  localparam int TOT    = NUM_CH * WORD_W;
  localparam int NCYC   = 2 * WORD_W;
  localparam time CLK_PERIOD = 20ns;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [TOT-1:0]    words_i = '0;
  logic              sclk_o, cs_o, busy_o, done_o;
  logic [NUM_CH-1:0] sdata_o;

  int compared = 0;
  int mismatched = 0;
  int sent = 0;
  int seen = 0;
  logic [TOT-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  par_dac_writer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .words_i(words_i),
    .sclk_o(sclk_o), .cs_o(cs_o), .sdata_o(sdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: frames, timing and lane contents
  bit                in_frame = 1'b0;
  int                cyc = 0;
  int                hi_cnt = 0;
  logic [WORD_W-1:0] rx [NUM_CH];
  logic [NUM_CH-1:0] prev_sd = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_o) begin
        chk(!in_frame, "R2", "cs inside frame", 64'(cyc), 64'(0));
        in_frame = 1'b1;
        cyc = 0;
        hi_cnt = 0;
      end
      if (in_frame) begin
        cyc++;
        if (cyc <= NCYC) begin
          chk(busy_o && !done_o, "R3", "busy/done in window", {busy_o, done_o}, 2'b10);
          chk(sclk_o == (cyc % 2 == 0), "R3", "sclk phase", 64'(sclk_o), 64'(cyc % 2 == 0));
          if (sclk_o) begin
            chk(sdata_o == prev_sd, "R4", "data stable in bit", 64'(sdata_o), 64'(prev_sd));
            for (int k = 0; k < NUM_CH; k++) rx[k] = {rx[k][WORD_W-2:0], sdata_o[k]};
            hi_cnt++;
          end
        end else begin
          chk(done_o && !busy_o, "R6", "done after last bit", {done_o, busy_o}, 2'b10);
          chk(hi_cnt == WORD_W, "R3", "sclk pulses", 64'(hi_cnt), 64'(WORD_W));
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "frame with nothing queued", 64'(1), 64'(0));
          end else begin
            logic [TOT-1:0] e;
            e = exp_q.pop_front();
            for (int k = 0; k < NUM_CH; k++)
              chk(rx[k] == e[k*WORD_W +: WORD_W], "R5", $sformatf("lane %0d word (R4 R8)", k),
                  64'(rx[k]), 64'(e[k*WORD_W +: WORD_W]));
          end
          seen++;
          in_frame = 1'b0;
        end
      end else begin
        chk(!done_o, "R6", "stray done", 64'(done_o), 64'(0));
        chk(!sclk_o && !busy_o && sdata_o == '0, "R1", "idle outputs",
            {sclk_o, busy_o, sdata_o}, 64'(0));
      end
      prev_sd = sdata_o;
    end
  end

  // Driver
  task automatic send(input logic [TOT-1:0] w, input bit poke);
    @(negedge clk);
    start_i = 1'b1;
    words_i = w;
    exp_q.push_back(w);
    sent++;
    @(negedge clk);
    start_i = 1'b0;
    words_i = ~w; // R8: inputs change after capture
    if (poke) begin // R7: stray start mid-transfer
      repeat (7) @(negedge clk);
      start_i = 1'b1;
      words_i = {TOT{1'b1}} ^ w ^ {NUM_CH{16'h5a5a}};
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  function automatic logic [TOT-1:0] pat(input int kind);
    logic [TOT-1:0] w;
    for (int k = 0; k < NUM_CH; k++) begin
      logic [WORD_W-1:0] v;
      case (kind)
        0: v = '0;
        1: v = '1;
        2: v = 16'ha5c3 ^ WORD_W'(k * 16'h1111);
        3: v = WORD_W'(1) << (k % WORD_W);
        4: v = (k == 0 || k == NUM_CH - 1) ? 16'h8001 : 16'h0000;
        default: v = WORD_W'($urandom);
      endcase
      w[k*WORD_W +: WORD_W] = v;
    end
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cs_o && !sclk_o && !busy_o && !done_o && sdata_o == '0, "R1", "reset state",
        {cs_o, sclk_o, busy_o, done_o}, 64'(0));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    send(pat(0), 1'b0); wait_done();
    send(pat(1), 1'b0); wait_done();
    send(pat(2), 1'b1); wait_done();   // R7 stray strobe
    send(pat(3), 1'b0); wait_done();
    send(pat(4), 1'b0);                // R5 edge lanes
    wait_done();
    // R9: strobe in the done cycle
    start_i = 1'b1;
    words_i = pat(5);
    exp_q.push_back(words_i);
    sent++;
    @(negedge clk);
    start_i = 1'b0;
    words_i = '0;
    chk(busy_o && cs_o, "R9", "back-to-back accepted", {busy_o, cs_o}, 2'b11);
    wait_done();
    for (int i = 0; i < 6; i++) begin
      send(pat(5), i % 2 == 1);
      wait_done();
    end
    repeat (5) @(negedge clk);
    chk(seen == sent, "R7", "frame count", 64'(seen), 64'(sent));
    chk(exp_q.size() == 0, "R7", "queue drained", 64'(exp_q.size()), 64'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule